// File: doc/BRIEF.md
# Strobe-Controlled Processor Clock Source Switch

This block picks the clock that drives a processor from two free-running sources. One is a slow clock supplied by a supervising controller. The other is a fast local oscillator, nominally 12 MHz. A one-bit select register holds the current choice. Reset or a pulse on the slow-request strobe puts it in the SLOW state. A falling edge on the fast-request strobe moves it to the FAST state. Both strobes are active-low and come from an external address decoder: one strobe per decoded location.

Each source is masked by its side of the select register. A masked source is forced high. The two masked clocks are ANDed into one mixed clock. A toggle flip-flop on the rising edges of the mixed clock gives the processor clock at half the selected frequency, about 6 MHz in fast mode. Because of this divider, a short low-then-high excursion on the mixed clock at a switch point moves the processor clock by one edge only. It cannot create a short processor clock phase.

Software drops to the slow clock by touching the slow location before it talks to the controller. It returns to full speed by touching the fast location. The select register has two states, SLOW and FAST. Its transitions are:
- FAST to SLOW on reset or on the slow strobe.
- SLOW to FAST on a falling edge of the fast strobe, when neither reset nor the slow strobe is active.

Top module: `cpu_clk_switch`

## Requirements
- R1: While rst_n is low, slow_active is 1 and cpu_clk is 0.
- R2: A falling edge of sel_fast_n, with rst_n and sel_slow_n both high, makes slow_active 0 (fast source selected).
- R3: sel_slow_n low makes slow_active 1 without waiting for any clock. The SLOW state is kept after sel_slow_n returns high.
- R4: When both strobes are low together, the slow selection wins. Holding sel_fast_n low does not switch sources; only its falling edge does.
- R5: With the fast source selected, cpu_clk toggles on each rising edge of clk_fast, so its period is twice the clk_fast period.
- R6: With the slow source selected, cpu_clk toggles on each rising edge of clk_slow, so its period is twice the clk_slow period.
- R7: A deselected source has no effect on cpu_clk. Its masked copy is held high.
- R8: When strobes change only while the selected source is low, no high or low phase of cpu_clk is shorter than half a clk_fast period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_slow | input | 1 | Slow clock from the supervising controller |
| clk_fast | input | 1 | Fast local oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_slow_n | input | 1 | Active-low strobe that requests the slow source |
| sel_fast_n | input | 1 | Active-low strobe that requests the fast source (acts on its falling edge) |
| cpu_clk | output | 1 | Processor clock, half the selected source frequency |
| slow_active | output | 1 | 1 while the slow source is selected |

## Verification
A wrong select state shows up at once on slow_active. Within one period of the newly chosen source, it also shows up as a cpu_clk period of the wrong length, because the period reveals which source is passing through the mask. A masking fault lets the other clock add rising edges to the mixed clock. The divider then shortens a cpu_clk phase or makes the period irregular within a few source cycles. The bench measures every cpu_clk phase while switching sources at random safe phases, and it measures the steady period in each mode.

// File: rtl/cksw_pkg.sv
`timescale 1ns/1ps
package cksw_pkg;
    // Select register state: value 1 means the slow source is in use
    typedef enum logic {
        SRC_FAST = 1'b0,
        SRC_SLOW = 1'b1
    } src_e;
endpackage

// File: rtl/cksw_select.sv
`timescale 1ns/1ps
module cksw_select
    import cksw_pkg::*;
(
    input  logic rst_n,
    input  logic slow_req_n,
    input  logic fast_req_n,
    output src_e src
);
    logic force_slow;
    src_e src_q;
    src_e src_on_fast_edge;

    // reset and slow request share the asynchronous set path
    always_comb begin
        force_slow = ~rst_n | ~slow_req_n;
    end

    always_comb begin
        unique case (src_q)
            SRC_SLOW: src_on_fast_edge = SRC_FAST;
            SRC_FAST: src_on_fast_edge = SRC_FAST;
            default:  src_on_fast_edge = SRC_SLOW;
        endcase
    end

    // state register: clocked by the fast strobe falling edge, set wins
    always_ff @(negedge fast_req_n or posedge force_slow) begin
        if (force_slow) begin
            src_q <= SRC_SLOW;
        end else begin
            src_q <= src_on_fast_edge;
        end
    end

    always_comb begin
        src = src_q;
    end
endmodule

// File: rtl/cksw_gate.sv
`timescale 1ns/1ps
module cksw_gate
    import cksw_pkg::*;
(
    input  logic clk_slow,
    input  logic clk_fast,
    input  src_e src,
    output logic gated_slow,
    output logic gated_fast,
    output logic mixed_clk
);
    logic en_slow;
    logic en_fast;

    always_comb begin
        en_slow = (src == SRC_SLOW);
        en_fast = (src == SRC_FAST);
        // a masked source parks high so the AND passes the other one
        gated_slow = clk_slow | ~en_slow;
        gated_fast = clk_fast | ~en_fast;
        mixed_clk  = gated_slow & gated_fast;
    end
endmodule

// File: rtl/cksw_div.sv
`timescale 1ns/1ps
module cksw_div #(
    parameter logic RESET_LEVEL = 1'b0
) (
    input  logic mixed_clk,
    input  logic rst_n,
    output logic div_q
);
    logic q;

    always_ff @(posedge mixed_clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= RESET_LEVEL;
        end else begin
            q <= ~q;
        end
    end

    always_comb begin
        div_q = q;
    end
endmodule

// File: rtl/cpu_clk_switch.sv
`timescale 1ns/1ps
module cpu_clk_switch
    import cksw_pkg::*;
(
    input  logic clk_slow,
    input  logic clk_fast,
    input  logic rst_n,
    input  logic sel_slow_n,
    input  logic sel_fast_n,
    output logic cpu_clk,
    output logic slow_active
);
    src_e src;
    logic gated_slow;
    logic gated_fast;
    logic mixed_clk;

    cksw_select u_select (
        .rst_n      (rst_n),
        .slow_req_n (sel_slow_n),
        .fast_req_n (sel_fast_n),
        .src        (src)
    );

    cksw_gate u_gate (
        .clk_slow   (clk_slow),
        .clk_fast   (clk_fast),
        .src        (src),
        .gated_slow (gated_slow),
        .gated_fast (gated_fast),
        .mixed_clk  (mixed_clk)
    );

    cksw_div #(.RESET_LEVEL(1'b0)) u_div (
        .mixed_clk (mixed_clk),
        .rst_n     (rst_n),
        .div_q     (cpu_clk)
    );

    always_comb begin
        slow_active = (src == SRC_SLOW);
    end
endmodule

// File: rtl/cpu_clk_switch_chk.sv
`timescale 1ns/1ps
module cpu_clk_switch_chk (
    input logic clk_slow,
    input logic clk_fast,
    input logic rst_n,
    input logic sel_slow_n,
    input logic cpu_clk,
    input logic slow_active,
    input logic gated_slow,
    input logic gated_fast
);
    always @(posedge clk_fast) begin
        if (!rst_n) begin
            a_r1_reset_state: assert (slow_active && !cpu_clk);
        end
    end

    a_r3_slow_strobe_holds: assert property (@(posedge clk_fast) disable iff (!rst_n)
        !sel_slow_n |-> slow_active);

    a_r7_fast_masked_high: assert property (@(posedge clk_fast) disable iff (!rst_n)
        slow_active |-> gated_fast);

    a_r7_slow_masked_high: assert property (@(posedge clk_slow) disable iff (!rst_n)
        !slow_active |-> gated_slow);

    a_r5_toggle_per_fast_edge: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (!slow_active && !$past(slow_active) && !$past(slow_active, 2))
            |-> (cpu_clk != $past(cpu_clk)));
endmodule

bind cpu_clk_switch cpu_clk_switch_chk u_chk (
    .clk_slow    (clk_slow),
    .clk_fast    (clk_fast),
    .rst_n       (rst_n),
    .sel_slow_n  (sel_slow_n),
    .cpu_clk     (cpu_clk),
    .slow_active (slow_active),
    .gated_slow  (gated_slow),
    .gated_fast  (gated_fast)
);

// File: tb/cpu_clk_switch_tb.sv
`timescale 1ns/1ps
module cpu_clk_switch_tb;
    localparam int FAST_PERIOD = 84;
    localparam int SLOW_PERIOD = 1310;
    localparam int SLOW_OFFSET = 17;
    localparam int SEED        = 1234;
    localparam int N_RANDOM    = 40;
    localparam int WATCHDOG_NS = 5_000_000;

    logic clk_slow = 1'b0;
    logic clk_fast = 1'b0;
    logic rst_n = 1'b0;
    logic sel_slow_n = 1'b1;
    logic sel_fast_n = 1'b1;
    logic cpu_clk;
    logic slow_active;

    int checks = 0;
    int failures = 0;
    logic model_slow = 1'b1;

    cpu_clk_switch u_dut (
        .clk_slow    (clk_slow),
        .clk_fast    (clk_fast),
        .rst_n       (rst_n),
        .sel_slow_n  (sel_slow_n),
        .sel_fast_n  (sel_fast_n),
        .cpu_clk     (cpu_clk),
        .slow_active (slow_active)
    );

    always #(FAST_PERIOD / 2) clk_fast = ~clk_fast;
    initial begin
        #(SLOW_OFFSET);
        forever #(SLOW_PERIOD / 2) clk_slow = ~clk_slow;
    end

    // phase monitor for R8
    realtime last_edge = 0.0;
    realtime min_phase = 1.0e9;
    bit armed = 1'b0;
    logic prev_clk = 1'b0;
    always @(cpu_clk, rst_n) begin
        if (!rst_n) begin
            armed = 1'b0;
        end else if (cpu_clk !== prev_clk) begin
            if (armed && ($realtime - last_edge) < min_phase) min_phase = $realtime - last_edge;
            last_edge = $realtime;
            armed = 1'b1;
        end
        prev_clk = cpu_clk;
    end

    function automatic logic exp_sel(input logic cur, input logic do_slow, input logic do_fast);
        if (do_slow) return 1'b1;
        if (do_fast) return 1'b0;
        return cur;
    endfunction

    task automatic check_bit(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic check_real(input string req, input realtime act, input realtime exp);
        checks++;
        if (act < exp - 0.5 || act > exp + 0.5) begin
            failures++;
            $display("FAIL %s actual=%0.3f expected=%0.3f", req, act, exp);
        end
    endtask

    // issue strobes while the selected source is low
    task automatic strobe(input logic do_slow, input logic do_fast);
        if (slow_active) begin
            @(negedge clk_slow);
            #(10 + ($urandom % 500));
        end else begin
            @(negedge clk_fast);
            #(4 + ($urandom % 30));
        end
        if (do_slow) sel_slow_n = 1'b0;
        #1;
        if (do_fast) sel_fast_n = 1'b0;
        #15;
        sel_slow_n = 1'b1;
        sel_fast_n = 1'b1;
        #5;
        model_slow = exp_sel(model_slow, do_slow, do_fast);
    endtask

    task automatic measure_period(output realtime per);
        realtime t0;
        @(posedge cpu_clk);
        t0 = $realtime;
        @(posedge cpu_clk);
        per = $realtime - t0;
    endtask

    initial begin
        #(WATCHDOG_NS);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        realtime per;
        void'($urandom(SEED));
        #300;
        check_bit("R1 slow_active in reset", slow_active, 1'b1);
        check_bit("R1 cpu_clk in reset", cpu_clk, 1'b0);
        rst_n = 1'b1;
        repeat (2) @(posedge clk_slow);
        measure_period(per);
        check_real("R6 slow period", per, 2.0 * SLOW_PERIOD);

        strobe(1'b0, 1'b1);
        check_bit("R2 fast strobe selects fast", slow_active, 1'b0);
        repeat (4) @(posedge clk_fast);
        measure_period(per);
        check_real("R5 R7 fast period", per, 2.0 * FAST_PERIOD);

        strobe(1'b1, 1'b0);
        check_bit("R3 slow strobe selects slow", slow_active, 1'b1);

        // R4: both together, slow wins
        strobe(1'b0, 1'b1);
        strobe(1'b1, 1'b1);
        check_bit("R4 both strobes slow wins", slow_active, 1'b1);

        // R4: a held fast strobe does not re-trigger
        @(negedge clk_slow);
        #20 sel_fast_n = 1'b0;
        #20;
        check_bit("R2 fast edge while slow", slow_active, 1'b0);
        @(negedge clk_fast);
        #5 sel_slow_n = 1'b0;
        #10 sel_slow_n = 1'b1;
        #10;
        check_bit("R3 slow kept after release", slow_active, 1'b1);
        #200;
        check_bit("R4 held fast strobe ignored", slow_active, 1'b1);
        @(negedge clk_slow);
        #20 sel_fast_n = 1'b1;
        #20;
        check_bit("R4 fast release ignored", slow_active, 1'b1);
        model_slow = 1'b1;

        for (int i = 0; i < N_RANDOM; i++) begin
            int kind;
            kind = $urandom % 3;
            strobe(kind == 0 || kind == 2, kind == 1 || kind == 2);
            check_bit("R2 R3 R4 random select", slow_active, model_slow);
            repeat (1 + ($urandom % 6)) @(posedge clk_fast);
        end

        // steady period after random run, mode known
        strobe(1'b0, 1'b1);
        repeat (4) @(posedge clk_fast);
        measure_period(per);
        check_real("R5 fast period after switching", per, 2.0 * FAST_PERIOD);

        checks++;
        if (min_phase < FAST_PERIOD / 2.0) begin
            failures++;
            $display("FAIL R8 shortest phase actual=%0.3f expected>=%0.3f", min_phase, FAST_PERIOD / 2.0);
        end

        // R1 mid-run reset from fast mode
        @(negedge clk_fast);
        #10 rst_n = 1'b0;
        #5;
        check_bit("R1 reset forces slow", slow_active, 1'b1);
        check_bit("R1 reset clears cpu_clk", cpu_clk, 1'b0);
        #200 rst_n = 1'b1;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule